// File: doc/BRIEF.md
# Translated DMA Channel Engine

This block owns a small bank of DMA channels and moves data between a device-side requester and system memory. Each channel holds a mode word (enable, direction and three status flags), a byte count and a logical start address. A requester names a channel, a direction and a byte length. The engine first checks that the channel agrees with the request. It then cuts the length down to the channel's remaining count and issues one 32-bit memory beat per word.

Every beat address is a logical address. It is translated through a local page table of 4 KiB pages before it reaches the memory port. A page table entry whose frame is zero, or an index past the table size, means the page is unmapped. When a channel does not agree with a request, its memory-error flag is raised and a per-channel bit in a non-maskable interrupt source register is set. Software reaches the channel registers, the table and the global registers through one word-wide register port with combinational read data.

Top module: `xdma_engine`

## Requirements
- R1: After reset all channel registers, the table base, the table limit and the interrupt source register read zero, `req_ready` is high and `mem_valid` is low.
- R2: Channel c has its mode word at 0x108+0x20*c, its byte count at 0x110+0x20*c and its address at 0x118+0x20*c, and each reads back what was written; the slot at 0x100+0x20*c is reserved, reads zero and ignores writes.
- R3: The table base register at 0x008 stores the written value with bit 31 forced to zero.
- R4: Accepting a request clears the channel's flag bits 8 (terminal count), 9 (memory error) and 10 (address error) before any new flag is set; bits 0 (enable) and 1 (memory-to-device) are kept.
- R5: If the channel's bit 0 is clear, or its bit 1 differs from `req_to_dev`, the engine sets bit 9 of that channel's mode word and bit c of the interrupt source register (0x018). It makes no memory beat and leaves the count unchanged.
- R6: A consistent request moves min(`req_len`, count) bytes. When it completes, bit 8 is set and the count drops by the bytes moved; a zero length still sets bit 8.
- R7: A beat at logical address A goes to physical address frame(A>>12) + A[11:0], with `mem_write` high for device-to-memory requests. An unmapped page stops the transfer before that beat, sets bit 10, withholds bit 8 and lowers the count only by the bytes already moved.
- R8: A page is unmapped when its frame is zero, when its index is at or beyond the table size, or when (index+1)*8 exceeds the table limit (0x010); a limit of zero unmaps every page.
- R9: A transfer that crosses a 4 KiB boundary translates each page separately, so consecutive beats may land in unrelated frames.
- R10: Entry i's frame word sits at 0x800+8*i and takes effect for the next request at once; the owner word at 0x804+8*i reads zero and does not change the mapping.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_write` hold; `mem_wdata` carries `dev_wdata`.
- R12: Writing ones to the interrupt source register clears those bits.
- R13: `req_ready` is low while a request is in progress, and `req_done` pulses for exactly one cycle at its end, after which `req_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Device request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_ch | input | $clog2(NUM_CH) | Channel named by the request |
| req_to_dev | input | 1 | 1: memory to device, 0: device to memory |
| req_len | input | LEN_W | Requested length in bytes |
| req_done | output | 1 | One-cycle end-of-request pulse |
| dev_wdata | input | 32 | Device data for device-to-memory beats |
| dev_wtake | output | 1 | Device word consumed this cycle |
| dev_rdata | output | 32 | Memory data for memory-to-device beats |
| dev_rvalid | output | 1 | `dev_rdata` valid this cycle |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 32 | Translated physical address |
| mem_write | output | 1 | Beat is a memory write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |

## Verification
The hardest state to reach is a transfer that starts on a mapped page and runs into an unmapped one partway through. This must leave a count reduced by only the beats already done, together with the address-error flag and no terminal-count flag. The bench sets this up by placing the start address eight bytes below a page boundary, with the next table entry left zero, and asking for more bytes than fit before the boundary. Page crossing into a different mapped frame and mid-run table limit cuts are reached the same way, by steering the start address to the last words of a page and by shrinking the limit register between requests.

// File: rtl/xdma_pkg.sv
// Shared constants for the translated DMA engine: register offsets,
// mode-word bit positions and the sequencer state type.
// Assumes a 12-bit register address space and 32-bit data.
package xdma_pkg;

    localparam int DATA_W      = 32;
    localparam int REG_AW      = 12;
    localparam int PAGE_BITS   = 12;

    localparam logic [REG_AW-1:0] OFF_TBL_BASE  = 12'h008;
    localparam logic [REG_AW-1:0] OFF_TBL_LIMIT = 12'h010;
    localparam logic [REG_AW-1:0] OFF_NMI_SRC   = 12'h018;

    localparam int FLG_EN      = 0;
    localparam int FLG_DIR     = 1;
    localparam int FLG_TC      = 8;
    localparam int FLG_MEMERR  = 9;
    localparam int FLG_ADDRERR = 10;

    localparam logic [DATA_W-1:0] FLAG_CLR_MASK =
        (32'd1 << FLG_TC) | (32'd1 << FLG_MEMERR) | (32'd1 << FLG_ADDRERR);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_END  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/xdma_xlate.sv
// Page translation table: holds one frame word per 4 KiB page and maps a
// logical address to a physical one combinationally.
// Assumes frames are byte addresses of page starts; zero frame = unmapped.
module xdma_xlate
    import xdma_pkg::*;
#(
    parameter int TBL_ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tw_we,
    input  logic [7:0]        tw_idx,
    input  logic [DATA_W-1:0] tw_frame,
    input  logic [7:0]        rd_idx,
    output logic [DATA_W-1:0] rd_frame,
    input  logic [DATA_W-1:0] limit,
    input  logic [DATA_W-1:0] look_addr,
    output logic              hit,
    output logic [DATA_W-1:0] phys
);
    localparam int IDXW = (TBL_ENTRIES > 1) ? $clog2(TBL_ENTRIES) : 1;
    localparam int PGW  = DATA_W - PAGE_BITS;

    logic [DATA_W-1:0] frame_q [TBL_ENTRIES];
    logic [PGW-1:0]    pg;
    logic [32:0]       end_byte;
    logic              in_tbl;
    logic              in_lim;
    logic [DATA_W-1:0] sel_frame;

    // One storage word per page entry, written through the register port.
    for (genvar e = 0; e < TBL_ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                frame_q[e] <= '0;
            else if (tw_we && (32'(tw_idx) == e))
                frame_q[e] <= tw_frame;
        end
    end

    // Lookup: index range, limit range and non-zero frame decide a hit.
    always_comb begin
        pg        = look_addr[DATA_W-1:PAGE_BITS];
        in_tbl    = 32'(pg) < TBL_ENTRIES;
        end_byte  = 33'({pg, 3'b000}) + 33'd8;
        in_lim    = end_byte <= {1'b0, limit};
        sel_frame = in_tbl ? frame_q[pg[IDXW-1:0]] : '0;
        hit       = in_tbl && in_lim && (sel_frame != '0);
        phys      = sel_frame + {{PGW{1'b0}}, look_addr[PAGE_BITS-1:0]};
    end

    // Register-port readback of a frame word.
    always_comb begin
        rd_frame = (32'(rd_idx) < TBL_ENTRIES) ? frame_q[rd_idx[IDXW-1:0]] : '0;
    end

endmodule

// File: rtl/xdma_chan_regs.sv
// Channel register bank (mode, count, address per channel) and the
// interrupt source register. Engine updates take priority over bus writes
// in the same cycle. Assumes bus channel/index fields are pre-decoded.
module xdma_chan_regs
    import xdma_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [2:0]                bus_ch,
    input  logic [1:0]                bus_idx,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic                      nmi_clr_we,
    output logic [NUM_CH-1:0]         nmi_src,
    input  logic [$clog2(NUM_CH)-1:0] eng_ch,
    input  logic                      eng_clr,
    input  logic [DATA_W-1:0]         eng_set,
    input  logic                      eng_cnt_we,
    input  logic [DATA_W-1:0]         eng_cnt_val,
    input  logic [NUM_CH-1:0]         eng_nmi_set,
    output logic [DATA_W-1:0]         eng_mode,
    output logic [DATA_W-1:0]         eng_cnt,
    output logic [DATA_W-1:0]         eng_addr
);
    localparam int CHW = $clog2(NUM_CH);

    logic [DATA_W-1:0] mode_q [NUM_CH];
    logic [DATA_W-1:0] cnt_q  [NUM_CH];
    logic [DATA_W-1:0] addr_q [NUM_CH];
    logic [NUM_CH-1:0] nmi_q;
    logic [CHW-1:0]    rsel;
    logic              rsel_ok;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Per-channel storage: bus write first, engine update overrides.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[c] <= '0;
                cnt_q[c]  <= '0;
                addr_q[c] <= '0;
            end else begin
                if (bus_we && (32'(bus_ch) == c)) begin
                    case (bus_idx)
                        2'd1:    mode_q[c] <= bus_wdata;
                        2'd2:    cnt_q[c]  <= bus_wdata;
                        2'd3:    addr_q[c] <= bus_wdata;
                        default: ;
                    endcase
                end
                if (32'(eng_ch) == c) begin
                    if (eng_clr || (eng_set != '0))
                        mode_q[c] <= (eng_clr ? (mode_q[c] & ~FLAG_CLR_MASK) : mode_q[c])
                                     | eng_set;
                    if (eng_cnt_we)
                        cnt_q[c] <= eng_cnt_val;
                end
            end
        end
    end

    // Interrupt source: write-one-to-clear from the bus, set by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_q <= '0;
        else
            nmi_q <= (nmi_q & ~(nmi_clr_we ? bus_wdata[NUM_CH-1:0] : '0)) | eng_nmi_set;
    end

    // Bus readback of the addressed channel slot.
    always_comb begin
        rsel      = bus_ch[CHW-1:0];
        rsel_ok   = 32'(bus_ch) < NUM_CH;
        bus_rdata = '0;
        if (rsel_ok) begin
            case (bus_idx)
                2'd1:    bus_rdata = mode_q[rsel];
                2'd2:    bus_rdata = cnt_q[rsel];
                2'd3:    bus_rdata = addr_q[rsel];
                default: bus_rdata = '0;
            endcase
        end
    end

    // Engine view of the channel it is serving.
    always_comb begin
        eng_mode = mode_q[eng_ch];
        eng_cnt  = cnt_q[eng_ch];
        eng_addr = addr_q[eng_ch];
        nmi_src  = nmi_q;
    end

endmodule

// File: rtl/xdma_seq.sv
// Request sequencer: accepts a request, checks channel consistency,
// clamps the length and walks one translated word beat at a time.
// Assumes the register bank returns the served channel combinationally.
module xdma_seq
    import xdma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int LEN_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [$clog2(NUM_CH)-1:0] req_ch,
    input  logic                      req_to_dev,
    input  logic [LEN_W-1:0]          req_len,
    output logic                      req_ready,
    output logic                      req_done,
    input  logic [DATA_W-1:0]         ch_mode,
    input  logic [DATA_W-1:0]         ch_cnt,
    input  logic [DATA_W-1:0]         ch_addr,
    input  logic                      xl_hit,
    input  logic [DATA_W-1:0]         xl_phys,
    output logic [DATA_W-1:0]         look_addr,
    output logic                      mem_valid,
    input  logic                      mem_ready,
    output logic [DATA_W-1:0]         mem_addr,
    output logic                      mem_write,
    output logic [$clog2(NUM_CH)-1:0] eng_ch,
    output logic                      eng_clr,
    output logic [DATA_W-1:0]         eng_set,
    output logic                      eng_cnt_we,
    output logic [DATA_W-1:0]         eng_cnt_val,
    output logic [NUM_CH-1:0]         eng_nmi_set
);
    localparam int CHW = $clog2(NUM_CH);

    seq_state_e        state_q;
    logic [CHW-1:0]    ch_q;
    logic              to_dev_q;
    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] rem_q;
    logic [DATA_W-1:0] moved_q;
    logic [DATA_W-1:0] len_ext;
    logic [DATA_W-1:0] clamp_len;
    logic [DATA_W-1:0] step;
    logic              chan_ok;

    // Datapath helpers: consistency, clamp and per-beat step.
    always_comb begin
        len_ext   = DATA_W'(req_len);
        clamp_len = (len_ext < ch_cnt) ? len_ext : ch_cnt;
        chan_ok   = ch_mode[FLG_EN] && (ch_mode[FLG_DIR] == req_to_dev);
        step      = (rem_q >= 32'd4) ? 32'd4 : rem_q;
    end

    // Control outputs and register-bank update commands.
    always_comb begin
        req_ready   = 1'b0;
        req_done    = 1'b0;
        mem_valid   = 1'b0;
        eng_clr     = 1'b0;
        eng_set     = '0;
        eng_cnt_we  = 1'b0;
        eng_cnt_val = ch_cnt - moved_q;
        eng_nmi_set = '0;
        eng_ch      = (state_q == ST_IDLE) ? req_ch : ch_q;
        look_addr   = cur_q;
        mem_addr    = xl_phys;
        mem_write   = !to_dev_q;
        case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    eng_clr = 1'b1;
                    if (!chan_ok) begin
                        eng_set     = 32'd1 << FLG_MEMERR;
                        eng_nmi_set = NUM_CH'(1) << req_ch;
                    end
                end
            end
            ST_RUN: begin
                if (rem_q == '0) begin
                    eng_set    = 32'd1 << FLG_TC;
                    eng_cnt_we = 1'b1;
                end else if (!xl_hit) begin
                    eng_set    = 32'd1 << FLG_ADDRERR;
                    eng_cnt_we = 1'b1;
                end else begin
                    mem_valid = 1'b1;
                end
            end
            ST_END:  req_done = 1'b1;
            default: ;
        endcase
    end

    // Sequencer state and transfer cursor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ch_q     <= '0;
            to_dev_q <= 1'b0;
            cur_q    <= '0;
            rem_q    <= '0;
            moved_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        ch_q     <= req_ch;
                        to_dev_q <= req_to_dev;
                        cur_q    <= ch_addr;
                        rem_q    <= clamp_len;
                        moved_q  <= '0;
                        state_q  <= chan_ok ? ST_RUN : ST_END;
                    end
                end
                ST_RUN: begin
                    if ((rem_q == '0) || !xl_hit) begin
                        state_q <= ST_END;
                    end else if (mem_ready) begin
                        cur_q   <= cur_q + 32'd4;
                        rem_q   <= rem_q - step;
                        moved_q <= moved_q + step;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xdma_engine.sv
// Top of the translated DMA engine: decodes the register port, joins the
// channel bank, translation table and sequencer, and forms the device and
// memory data paths. Assumes word-aligned register accesses.
module xdma_engine
    import xdma_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int TBL_ENTRIES = 32,
    parameter int LEN_W       = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [11:0]               reg_addr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [$clog2(NUM_CH)-1:0] req_ch,
    input  logic                      req_to_dev,
    input  logic [LEN_W-1:0]          req_len,
    output logic                      req_done,
    input  logic [31:0]               dev_wdata,
    output logic                      dev_wtake,
    output logic [31:0]               dev_rdata,
    output logic                      dev_rvalid,
    output logic                      mem_valid,
    input  logic                      mem_ready,
    output logic [31:0]               mem_addr,
    output logic                      mem_write,
    output logic [31:0]               mem_wdata,
    input  logic [31:0]               mem_rdata
);
    localparam int CHW = $clog2(NUM_CH);

    logic [DATA_W-1:0] base_q;
    logic [DATA_W-1:0] limit_q;
    logic              is_ch;
    logic              is_tbl;
    logic              tbl_frame_sel;
    logic [DATA_W-1:0] ch_rdata;
    logic [DATA_W-1:0] tbl_rdata;
    logic [NUM_CH-1:0] nmi_q;
    logic [DATA_W-1:0] seq_cursor;
    logic              xl_hit;
    logic [DATA_W-1:0] xl_phys;
    logic [CHW-1:0]    eng_ch;
    logic              eng_clr;
    logic [DATA_W-1:0] eng_set;
    logic              eng_cnt_we;
    logic [DATA_W-1:0] eng_cnt_val;
    logic [NUM_CH-1:0] eng_nmi_set;
    logic [DATA_W-1:0] eng_mode;
    logic [DATA_W-1:0] eng_cnt;
    logic [DATA_W-1:0] eng_addr;
    logic              beat;

    // Address decode of the register port.
    always_comb begin
        is_ch         = (reg_addr[11:8] == 4'h1) && (reg_addr[2:0] == 3'b000);
        is_tbl        = reg_addr[11] && (reg_addr[1:0] == 2'b00);
        tbl_frame_sel = is_tbl && !reg_addr[2];
    end

    // Global table base (bit 31 dropped) and table limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == OFF_TBL_BASE)  base_q  <= reg_wdata & 32'h7fff_ffff;
            if (reg_addr == OFF_TBL_LIMIT) limit_q <= reg_wdata;
        end
    end

    xdma_chan_regs #(.NUM_CH(NUM_CH)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (reg_we && is_ch),
        .bus_ch     (reg_addr[7:5]),
        .bus_idx    (reg_addr[4:3]),
        .bus_wdata  (reg_wdata),
        .bus_rdata  (ch_rdata),
        .nmi_clr_we (reg_we && (reg_addr == OFF_NMI_SRC)),
        .nmi_src    (nmi_q),
        .eng_ch     (eng_ch),
        .eng_clr    (eng_clr),
        .eng_set    (eng_set),
        .eng_cnt_we (eng_cnt_we),
        .eng_cnt_val(eng_cnt_val),
        .eng_nmi_set(eng_nmi_set),
        .eng_mode   (eng_mode),
        .eng_cnt    (eng_cnt),
        .eng_addr   (eng_addr)
    );

    xdma_xlate #(.TBL_ENTRIES(TBL_ENTRIES)) xlate_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tw_we    (reg_we && tbl_frame_sel),
        .tw_idx   (reg_addr[10:3]),
        .tw_frame (reg_wdata),
        .rd_idx   (reg_addr[10:3]),
        .rd_frame (tbl_rdata),
        .limit    (limit_q),
        .look_addr(seq_cursor),
        .hit      (xl_hit),
        .phys     (xl_phys)
    );

    xdma_seq #(.NUM_CH(NUM_CH), .LEN_W(LEN_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ch     (req_ch),
        .req_to_dev (req_to_dev),
        .req_len    (req_len),
        .req_ready  (req_ready),
        .req_done   (req_done),
        .ch_mode    (eng_mode),
        .ch_cnt     (eng_cnt),
        .ch_addr    (eng_addr),
        .xl_hit     (xl_hit),
        .xl_phys    (xl_phys),
        .look_addr  (seq_cursor),
        .mem_valid  (mem_valid),
        .mem_ready  (mem_ready),
        .mem_addr   (mem_addr),
        .mem_write  (mem_write),
        .eng_ch     (eng_ch),
        .eng_clr    (eng_clr),
        .eng_set    (eng_set),
        .eng_cnt_we (eng_cnt_we),
        .eng_cnt_val(eng_cnt_val),
        .eng_nmi_set(eng_nmi_set)
    );

    // Device and memory data paths around each accepted beat.
    always_comb begin
        beat       = mem_valid && mem_ready;
        mem_wdata  = dev_wdata;
        dev_wtake  = beat && mem_write;
        dev_rvalid = beat && !mem_write;
        dev_rdata  = mem_rdata;
    end

    // Register read mux.
    always_comb begin
        if (reg_addr == OFF_TBL_BASE)       reg_rdata = base_q;
        else if (reg_addr == OFF_TBL_LIMIT) reg_rdata = limit_q;
        else if (reg_addr == OFF_NMI_SRC)   reg_rdata = DATA_W'(nmi_q);
        else if (is_ch)                     reg_rdata = ch_rdata;
        else if (tbl_frame_sel)             reg_rdata = tbl_rdata;
        else                                reg_rdata = '0;
    end

endmodule

// File: rtl/xdma_engine_chk.sv
// Protocol checker for xdma_engine, attached with bind. Watches the memory
// handshake, request handshake, interrupt source and beat page offset.
module xdma_engine_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              req_done,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [31:0]       mem_addr,
    input logic              mem_write,
    input logic [NUM_CH-1:0] nmi_q,
    input logic [31:0]       cursor
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)); // R11

    AST_DIR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && $past(mem_valid) |-> $stable(mem_write)); // R11

    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_valid); // R13

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done && req_ready); // R13

    AST_NMI_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((nmi_q & ~$past(nmi_q)) != '0) |-> req_done); // R5

    AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[11:0] == cursor[11:0]); // R7

endmodule

bind xdma_engine xdma_engine_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .req_done (req_done),
    .mem_valid(mem_valid),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .mem_write(mem_write),
    .nmi_q    (nmi_q),
    .cursor   (seq_cursor)
);

// File: tb/xdma_engine_tb.sv
// Directed bench for xdma_engine: one task per scenario, each checking
// its own results against values worked out from the requirements.
module xdma_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_ch = '0;
    logic        req_to_dev = 1'b0;
    logic [15:0] req_len = '0;
    logic        req_done;
    logic [31:0] dev_wdata = 32'hCAFE_0011;
    logic        dev_wtake;
    logic [31:0] dev_rdata;
    logic        dev_rvalid;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_write;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int lat = 0;
    int nbeats = 0;
    int start_nb = 0;
    logic [31:0] b_addr [64];
    logic        b_wr   [64];
    logic [31:0] b_wd   [64];

    always #5 clk = ~clk;

    xdma_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_ch(req_ch),
        .req_to_dev(req_to_dev), .req_len(req_len), .req_done(req_done),
        .dev_wdata(dev_wdata), .dev_wtake(dev_wtake), .dev_rdata(dev_rdata), .dev_rvalid(dev_rvalid),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_write(mem_write), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: one idle cycle, then accept and record the beat.
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_valid) begin
            if (lat == 1) begin
                lat = 0;
                mem_ready = 1'b1;
                mem_rdata = mem_addr ^ 32'h5A5A_0000;
                if (nbeats < 64) begin
                    b_addr[nbeats] = mem_addr;
                    b_wr[nbeats]   = mem_write;
                    b_wd[nbeats]   = mem_wdata;
                end
                nbeats = nbeats + 1;
            end else begin
                lat = lat + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL R13 watchdog expired: act=%0d exp=<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    function automatic logic [11:0] chreg(input int ch, input int idx);
        return 12'(32'h100 + ch * 32'h20 + idx * 8);
    endfunction

    task automatic setup_ch(input int ch, input logic [31:0] mode,
                            input logic [31:0] cnt, input logic [31:0] addr);
        wr(chreg(ch, 1), mode);
        wr(chreg(ch, 2), cnt);
        wr(chreg(ch, 3), addr);
    endtask

    // Issue one request, wait for done, check ready/done behaviour.
    task automatic run_req(input string req, input int ch, input logic to_dev, input int len);
        int guard;
        logic busy_ok;
        busy_ok = 1'b1;
        start_nb = nbeats;
        @(negedge clk);
        req_ch = 2'(ch); req_to_dev = to_dev; req_len = 16'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!req_done && guard < 500) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            guard++;
        end
        chk({req, " R13 done seen"}, 32'(req_done), 32'd1);
        chk({req, " R13 busy while running"}, 32'(busy_ok), 32'd1);
        @(negedge clk);
        chk({req, " R13 done one cycle"}, {31'd0, req_done}, 32'd0);
        chk({req, " R13 ready after"}, {31'd0, req_ready}, 32'd1);
    endtask

    task automatic chk_beat(input string req, input int k, input logic [31:0] addr, input logic wr_exp);
        chk({req, " beat addr"}, b_addr[start_nb + k], addr);
        chk({req, " beat dir"}, 32'(b_wr[start_nb + k]), 32'(wr_exp));
        if (wr_exp) chk({req, " R11 beat data"}, b_wd[start_nb + k], dev_wdata);
    endtask

    task automatic t_reset();
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
        rd_chk("R1 nmi", 12'h018, 32'd0);
        rd_chk("R1 limit", 12'h010, 32'd0);
        rd_chk("R1 base", 12'h008, 32'd0);
        rd_chk("R1 mode ch0", chreg(0, 1), 32'd0);
        rd_chk("R1 count ch3", chreg(3, 2), 32'd0);
    endtask

    task automatic t_regs();
        setup_ch(2, 32'h3, 32'h40, 32'h1234_5000);
        wr(chreg(2, 0), 32'hFFFF_FFFF);
        rd_chk("R2 mode", chreg(2, 1), 32'h3);
        rd_chk("R2 count", chreg(2, 2), 32'h40);
        rd_chk("R2 addr", chreg(2, 3), 32'h1234_5000);
        rd_chk("R2 reserved", chreg(2, 0), 32'h0);
        wr(12'h008, 32'hFFFF_F000);
        rd_chk("R3 base mask", 12'h008, 32'h7FFF_F000);
    endtask

    task automatic t_limit_zero();
        wr(12'h808, 32'h0008_0000);
        wr(12'h810, 32'h0005_0000);
        setup_ch(0, 32'h1, 32'd16, 32'h1000);
        run_req("R8 limit0", 0, 1'b0, 8);
        chk("R8 limit0 no beats", 32'(nbeats - start_nb), 32'd0);
        rd_chk("R8 limit0 addr err", chreg(0, 1), 32'h401);
        rd_chk("R8 limit0 count", chreg(0, 2), 32'd16);
    endtask

    task automatic t_basic();
        wr(12'h010, 32'd256);
        setup_ch(0, 32'h1, 32'd16, 32'h1010);
        run_req("R7 basic", 0, 1'b0, 8);
        chk("R6 basic beats", 32'(nbeats - start_nb), 32'd2);
        chk_beat("R7 b0", 0, 32'h0008_0010, 1'b1);
        chk_beat("R7 b1", 1, 32'h0008_0014, 1'b1);
        rd_chk("R6 basic mode", chreg(0, 1), 32'h101);
        rd_chk("R6 basic count", chreg(0, 2), 32'd8);
    endtask

    task automatic t_clamp();
        setup_ch(1, 32'h0703, 32'd8, 32'h1000);
        run_req("R6 clamp", 1, 1'b1, 20);
        chk("R6 clamp beats", 32'(nbeats - start_nb), 32'd2);
        chk_beat("R7 rd0", 0, 32'h0008_0000, 1'b0);
        chk_beat("R7 rd1", 1, 32'h0008_0004, 1'b0);
        rd_chk("R4 flags cleared then TC", chreg(1, 1), 32'h103);
        rd_chk("R6 clamp count", chreg(1, 2), 32'd0);
        run_req("R6 zero", 1, 1'b1, 4);
        chk("R6 zero beats", 32'(nbeats - start_nb), 32'd0);
        rd_chk("R6 zero mode", chreg(1, 1), 32'h103);
    endtask

    task automatic t_mismatch();
        run_req("R5 dir", 1, 1'b0, 4);
        chk("R5 dir no beats", 32'(nbeats - start_nb), 32'd0);
        rd_chk("R5 dir mode", chreg(1, 1), 32'h203);
        rd_chk("R5 nmi ch1", 12'h018, 32'h2);
        setup_ch(3, 32'h0, 32'd12, 32'h1000);
        run_req("R5 disabled", 3, 1'b0, 4);
        rd_chk("R5 dis mode", chreg(3, 1), 32'h200);
        rd_chk("R5 dis count", chreg(3, 2), 32'd12);
        rd_chk("R5 nmi ch1 ch3", 12'h018, 32'hA);
        wr(12'h018, 32'h2);
        rd_chk("R12 w1c", 12'h018, 32'h8);
        wr(12'h018, 32'h8);
        rd_chk("R12 w1c all", 12'h018, 32'h0);
    endtask

    task automatic t_unmapped();
        setup_ch(0, 32'h1, 32'd8, 32'h3000);
        run_req("R7 zero frame", 0, 1'b0, 8);
        chk("R7 zero frame beats", 32'(nbeats - start_nb), 32'd0);
        rd_chk("R7 zero frame mode", chreg(0, 1), 32'h401);
        rd_chk("R7 zero frame count", chreg(0, 2), 32'd8);
        wr(12'h010, 32'd16);
        wr(chreg(0, 3), 32'h2000);
        run_req("R8 past limit", 0, 1'b0, 8);
        chk("R8 past limit beats", 32'(nbeats - start_nb), 32'd0);
        rd_chk("R8 past limit mode", chreg(0, 1), 32'h401);
        wr(12'h010, 32'd256);
        wr(chreg(0, 3), 32'h0040_0000);
        run_req("R8 past table", 0, 1'b0, 8);
        chk("R8 past table beats", 32'(nbeats - start_nb), 32'd0);
        rd_chk("R8 past table mode", chreg(0, 1), 32'h401);
    endtask

    task automatic t_cross();
        setup_ch(0, 32'h1, 32'd16, 32'h1FF8);
        run_req("R9 cross", 0, 1'b0, 16);
        chk("R9 cross beats", 32'(nbeats - start_nb), 32'd4);
        chk_beat("R9 c0", 0, 32'h0008_0FF8, 1'b1);
        chk_beat("R9 c1", 1, 32'h0008_0FFC, 1'b1);
        chk_beat("R9 c2", 2, 32'h0005_0000, 1'b1);
        chk_beat("R9 c3", 3, 32'h0005_0004, 1'b1);
        rd_chk("R9 cross mode", chreg(0, 1), 32'h101);
        rd_chk("R9 cross count", chreg(0, 2), 32'd0);
    endtask

    task automatic t_partial();
        setup_ch(0, 32'h1, 32'd16, 32'h2FF8);
        run_req("R7 partial", 0, 1'b0, 16);
        chk("R7 partial beats", 32'(nbeats - start_nb), 32'd2);
        chk_beat("R7 p0", 0, 32'h0005_0FF8, 1'b1);
        rd_chk("R7 partial mode", chreg(0, 1), 32'h401);
        rd_chk("R7 partial count", chreg(0, 2), 32'd8);
    endtask

    task automatic t_frame_update();
        wr(12'h808, 32'h0009_0000);
        wr(12'h80C, 32'hFFFF_FFFF);
        rd_chk("R10 frame readback", 12'h808, 32'h0009_0000);
        rd_chk("R10 owner reads zero", 12'h80C, 32'h0);
        setup_ch(0, 32'h1, 32'd4, 32'h1100);
        run_req("R10 remap", 0, 1'b0, 4);
        chk("R10 remap beats", 32'(nbeats - start_nb), 32'd1);
        chk_beat("R10 remap b0", 0, 32'h0009_0100, 1'b1);
        rd_chk("R10 remap mode", chreg(0, 1), 32'h101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_limit_zero();
        t_basic();
        t_clamp();
        t_mismatch();
        t_unmapped();
        t_cross();
        t_partial();
        t_frame_update();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule